// File: doc/BRIEF.md
# Aging Priority-Elevation Write Arbiter

This block decides which of several write channels may use a single shared memory bank. Only one channel holds the bank at a time. A grant lasts until the owning channel signals completion, and the bank then stays idle for one cycle before the next grant is issued.

Each channel has its own wait limit, held in an 8-bit field of one 32-bit configuration register. While a channel keeps requesting and another channel owns the bank, a per-channel counter advances once per clock. When the counter reaches the channel's limit, the request is promoted to urgent. An urgent request beats every normal request. Within each class the grant rotates round-robin. A limit of zero turns promotion off for that channel.

The limits can be changed through a simple write/read port. A channel's field is locked while that channel owns the bank, so a new limit cannot disturb a wait that is in progress. The urgent flags are also driven out as the priority indication that goes with each request.

Top module: `wr_age_arbiter`

## Requirements
- R1: After reset, no channel is granted, no urgent flag is set, and the register reads 0x0000_0404 (every limit field is 4).
- R2: The limit of channel k sits at register bits [8k+7:8k]: channel 0 at 7:0 and channel 1 at 15:8. Bits 31:16 read as zero. A write to a field whose channel is not granted shows on the read port from the next cycle.
- R3: While a channel is granted, a register write leaves that channel's field unchanged. A field whose channel is not granted is still updated by the same write.
- R4: At most one grant is asserted at any time. A new grant is only given to a channel whose request was high at the clock edge that issued the grant.
- R5: A grant stays asserted until the granted channel raises done. It is removed at the next clock edge. A new grant is issued no earlier than the edge after that.
- R6: With limit L > 0, a channel that requests without interruption while another channel is granted raises urgent at the L-th clock edge of that wait, and not before.
- R7: A channel whose limit field is zero never raises urgent.
- R8: Urgent clears, and the wait count restarts from zero, at the edge where the channel is granted or at the first edge where its request is low.
- R9: When the bank is free, an urgent requester is granted ahead of any normal requester. Within the urgent class and within the normal class, grants rotate round-robin, so two channels that request continuously alternate.
- R10: Urgent stays asserted while the channel keeps requesting and remains ungranted, however long the wait lasts beyond L cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all waiting is counted in its cycles |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_CH | Per-channel bank request |
| done_i | input | N_CH | Per-channel end of the granted transfer |
| gnt_o | output | N_CH | Per-channel grant, at most one set |
| urg_o | output | N_CH | Per-channel urgent-priority indication |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | REG_W | Register write data |
| cfg_rdata_o | output | REG_W | Register read data |

## Verification
The checker enforces on every cycle the rules that involve one or two clock edges: a single grant, grants going only to requesters, holding the grant until done and dropping it one edge later, urgent winning at a grant edge, the field lock while a channel is granted, and urgent being held, cleared or suppressed by a zero limit. The exact edge at which urgent rises after L waiting cycles, round-robin alternation over many grants, and the read-back of field positions and reserved bits need multi-cycle stories. Those are shown only by the bench's directed scenarios and by its cycle model compared against the outputs during random traffic.

// File: rtl/wr_age_pkg.sv
package wr_age_pkg;
  localparam int unsigned REG_W_DEF   = 32;
  localparam int unsigned CNT_W_DEF   = 8;
  localparam int unsigned N_CH_DEF    = 2;
  localparam int unsigned RST_CNT_DEF = 4;
endpackage

// File: rtl/wr_age_cfg.sv
module wr_age_cfg #(
  parameter int unsigned N_CH    = wr_age_pkg::N_CH_DEF,
  parameter int unsigned CNT_W   = wr_age_pkg::CNT_W_DEF,
  parameter int unsigned REG_W   = wr_age_pkg::REG_W_DEF,
  parameter int unsigned RST_CNT = wr_age_pkg::RST_CNT_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [REG_W-1:0]        wdata_i,
  input  logic [N_CH-1:0]         lock_i,
  output logic [N_CH*CNT_W-1:0]   limit_o,
  output logic [REG_W-1:0]        rdata_o
);
  localparam int unsigned FLD_W = N_CH * CNT_W;

  for (genvar g = 0; g < N_CH; g++) begin : g_fld
    logic [CNT_W-1:0] fld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fld_q <= CNT_W'(RST_CNT);
      end else if (we_i && !lock_i[g]) begin
        // field frozen while its channel owns the bank
        fld_q <= wdata_i[g*CNT_W +: CNT_W];
      end
    end
    assign limit_o[g*CNT_W +: CNT_W] = fld_q;
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[FLD_W-1:0] = limit_o;
  end
endmodule

// File: rtl/wr_age_timer.sv
module wr_age_timer #(
  parameter int unsigned CNT_W = wr_age_pkg::CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             busy_i,
  input  logic             win_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             urg_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             urg_q;
  logic             clr;

  assign clr = !req_i || busy_i || win_i || (limit_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      urg_q <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      urg_q <= 1'b0;
    end else if (!urg_q) begin
      if (cnt_q >= limit_i - CNT_W'(1)) begin
        cnt_q <= limit_i;   // saturate, no wrap
        urg_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign urg_o = urg_q;
endmodule

// File: rtl/wr_age_grant.sv
module wr_age_grant #(
  parameter int unsigned N_CH = wr_age_pkg::N_CH_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] req_i,
  input  logic [N_CH-1:0] urg_i,
  input  logic [N_CH-1:0] done_i,
  output logic [N_CH-1:0] gnt_o,
  output logic [N_CH-1:0] win_o
);
  localparam int unsigned PTR_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [N_CH-1:0]  gnt_q, gnt_d, pick, urg_req;
  logic [PTR_W-1:0] ptr_u_q, ptr_n_q, ptr_u_d, ptr_n_d;
  logic             use_urg;

  function automatic logic [N_CH-1:0] rr_pick(input logic [N_CH-1:0] r,
                                              input logic [PTR_W-1:0] p);
    logic [N_CH-1:0] res;
    logic            found;
    res   = '0;
    found = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      int idx;
      idx = (int'(p) + i) % N_CH;
      if (!found && r[idx[PTR_W-1:0]]) begin
        res[idx[PTR_W-1:0]] = 1'b1;
        found = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic logic [PTR_W-1:0] next_ptr(input logic [N_CH-1:0] oh);
    int nxt;
    nxt = 0;
    for (int i = 0; i < N_CH; i++) begin
      if (oh[i]) nxt = (i + 1) % N_CH;
    end
    return PTR_W'(nxt);
  endfunction

  assign urg_req = req_i & urg_i;
  assign use_urg = (urg_req != '0);

  always_comb begin
    ptr_u_d = ptr_u_q;
    ptr_n_d = ptr_n_q;
    pick    = '0;
    win_o   = '0;
    if (gnt_q != '0) begin
      gnt_d = ((done_i & gnt_q) != '0) ? '0 : gnt_q;
    end else begin
      if (use_urg) begin
        pick    = rr_pick(urg_req, ptr_u_q);
        ptr_u_d = next_ptr(pick);
      end else if (req_i != '0) begin
        pick    = rr_pick(req_i, ptr_n_q);
        ptr_n_d = next_ptr(pick);
      end
      gnt_d = pick;
      win_o = pick;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q   <= '0;
      ptr_u_q <= '0;
      ptr_n_q <= '0;
    end else begin
      gnt_q   <= gnt_d;
      ptr_u_q <= ptr_u_d;
      ptr_n_q <= ptr_n_d;
    end
  end

  assign gnt_o = gnt_q;
endmodule

// File: rtl/wr_age_arbiter.sv
module wr_age_arbiter #(
  parameter int unsigned N_CH    = wr_age_pkg::N_CH_DEF,
  parameter int unsigned CNT_W   = wr_age_pkg::CNT_W_DEF,
  parameter int unsigned REG_W   = wr_age_pkg::REG_W_DEF,
  parameter int unsigned RST_CNT = wr_age_pkg::RST_CNT_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  req_i,
  input  logic [N_CH-1:0]  done_i,
  output logic [N_CH-1:0]  gnt_o,
  output logic [N_CH-1:0]  urg_o,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o
);
  localparam int unsigned FLD_W = N_CH * CNT_W;

  logic [FLD_W-1:0] limit;
  logic [N_CH-1:0]  gnt, win, urg;

  wr_age_cfg #(
    .N_CH(N_CH), .CNT_W(CNT_W), .REG_W(REG_W), .RST_CNT(RST_CNT)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .lock_i  (gnt),
    .limit_o (limit),
    .rdata_o (cfg_rdata_o)
  );

  wr_age_grant #(.N_CH(N_CH)) u_grant (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .urg_i  (urg),
    .done_i (done_i),
    .gnt_o  (gnt),
    .win_o  (win)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    wr_age_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req_i[g]),
      .busy_i  (gnt[g]),
      .win_i   (win[g]),
      .limit_i (limit[g*CNT_W +: CNT_W]),
      .urg_o   (urg[g])
    );
  end

  assign gnt_o = gnt;
  assign urg_o = urg;
endmodule

// File: rtl/wr_age_arbiter_chk.sv
module wr_age_arbiter_chk #(
  parameter int unsigned N_CH  = 2,
  parameter int unsigned CNT_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [N_CH-1:0]       req_i,
  input logic [N_CH-1:0]       done_i,
  input logic                  cfg_we_i,
  input logic [N_CH-1:0]       gnt_o,
  input logic [N_CH-1:0]       urg_o,
  input logic [N_CH*CNT_W-1:0] fld_i
);
  AST_ONE_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R4

  AST_GNT_TO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && $past(gnt_o) == '0) |-> ((gnt_o & $past(req_i)) == gnt_o)); // R4

  AST_GNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && (done_i & gnt_o) == '0) |=> (gnt_o == $past(gnt_o))); // R5

  AST_GNT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((done_i & gnt_o) != '0) |=> (gnt_o == '0)); // R5

  AST_URG_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && $past(gnt_o) == '0 && $past(urg_o & req_i) != '0)
      |-> ((gnt_o & $past(urg_o)) != '0)); // R9

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    AST_CFG_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && gnt_o[g]) |=> (fld_i[g*CNT_W +: CNT_W] == $past(fld_i[g*CNT_W +: CNT_W]))); // R3

    AST_ZERO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fld_i[g*CNT_W +: CNT_W] == '0) |=> !urg_o[g]); // R7

    AST_URG_DROP_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i[g] |=> !urg_o[g]); // R8

    AST_URG_DROP_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[g] |-> !urg_o[g]); // R8

    AST_URG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (urg_o[g] && req_i[g] && fld_i[g*CNT_W +: CNT_W] != '0) |=> (urg_o[g] || gnt_o[g])); // R10
  end
endmodule

bind wr_age_arbiter wr_age_arbiter_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .done_i   (done_i),
  .cfg_we_i (cfg_we_i),
  .gnt_o    (gnt_o),
  .urg_o    (urg_o),
  .fld_i    (cfg_rdata_o[FLD_W-1:0])
);

// File: tb/tb_wr_age_arbiter.sv
module tb_wr_age_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req = '0, done = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [1:0]  gnt_o, urg_o;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wr_age_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .done_i(done),
    .gnt_o(gnt_o), .urg_o(urg_o),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata)
  );

  // cycle model built from the requirements
  logic [1:0] m_gnt, m_urg;
  int         m_cnt [2];
  logic [7:0] m_fld [2];
  int         m_pu, m_pn;

  function automatic logic [1:0] rr(input logic [1:0] r, input int p);
    logic [1:0] res = '0;
    for (int k = 0; k < 2; k++) begin
      int idx = (p + k) % 2;
      if (res == '0 && r[idx]) res[idx] = 1'b1;
    end
    return res;
  endfunction

  function automatic int nxt(input logic [1:0] oh);
    return oh[0] ? 1 : 0;
  endfunction

  function automatic logic [31:0] m_rd();
    return {16'h0, m_fld[1], m_fld[0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gnt = '0; m_urg = '0; m_pu = 0; m_pn = 0;
      for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_fld[i] = 8'd4; end
    end else begin
      logic [1:0] ng, us;
      ng = '0;
      us = req & m_urg;
      if (m_gnt != '0) ng = ((done & m_gnt) != '0) ? 2'b00 : m_gnt;
      else if (us != '0) begin ng = rr(us, m_pu); m_pu = nxt(ng); end
      else if (req != '0) begin ng = rr(req, m_pn); m_pn = nxt(ng); end
      for (int i = 0; i < 2; i++) begin
        if (!req[i] || m_gnt[i] || ng[i] || m_fld[i] == 0) begin
          m_cnt[i] = 0; m_urg[i] = 1'b0;
        end else if (!m_urg[i]) begin
          if (m_cnt[i] + 1 >= int'(m_fld[i])) begin m_cnt[i] = int'(m_fld[i]); m_urg[i] = 1'b1; end
          else m_cnt[i] = m_cnt[i] + 1;
        end
      end
      for (int i = 0; i < 2; i++) if (we && !m_gnt[i]) m_fld[i] = wdata[8*i +: 8];
      m_gnt = ng;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R4 R5 R9 grant vs model", {30'h0, gnt_o}, {30'h0, m_gnt});
    chk("R6 R7 R8 R10 urgent vs model", {30'h0, urg_o}, {30'h0, m_urg});
    chk("R2 R3 register vs model", rdata, m_rd());
  endtask

  task automatic wr(input logic [31:0] v);
    we = 1'b1; wdata = v; tick(); we = 1'b0;
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] prev;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 reset grant", {30'h0, gnt_o}, 32'h0);
    chk("R1 reset urgent", {30'h0, urg_o}, 32'h0);
    chk("R1 reset register", rdata, 32'h0000_0404);
    rst_n = 1'b1;

    // R2: field placement, reserved bits zero
    wr(32'hA5A5_0302);
    chk("R2 readback", rdata, 32'h0000_0302);

    // R6 / R10 / R3 / R5 / R8: ch1 waits behind ch0, limit 3
    req = 2'b01; tick();
    chk("R5 first grant", {30'h0, gnt_o}, 32'h1);
    req = 2'b11;
    tick(); tick();
    chk("R6 urgent not before L", {31'h0, urg_o[1]}, 32'h0);
    tick();
    chk("R6 urgent at L", {31'h0, urg_o[1]}, 32'h1);
    repeat (6) tick();
    chk("R10 urgent held", {31'h0, urg_o[1]}, 32'h1);
    wr(32'h0000_0509);
    chk("R3 locked field kept", rdata, 32'h0000_0502);
    chk("R10 urgent after limit raise", {31'h0, urg_o[1]}, 32'h1);
    done = 2'b01; tick();
    chk("R5 grant dropped after done", {30'h0, gnt_o}, 32'h0);
    done = 2'b00; req = 2'b10; tick();
    chk("R5 next grant", {30'h0, gnt_o}, 32'h2);
    chk("R8 urgent cleared on grant", {31'h0, urg_o[1]}, 32'h0);
    done = 2'b10; tick(); done = 2'b00; req = 2'b00; tick();

    // R7: zero limit disables promotion
    wr(32'h0000_000A);
    req = 2'b01; tick(); req = 2'b11;
    repeat (20) tick();
    chk("R7 zero limit never urgent", {31'h0, urg_o[1]}, 32'h0);
    done = 2'b01; tick(); done = 2'b00; req = 2'b10; tick();
    done = 2'b10; tick(); done = 2'b00; req = 2'b00; tick();

    // R8: withdraw clears and restarts the wait
    wr(32'h0000_0203);
    req = 2'b01; tick(); req = 2'b11; tick(); tick();
    chk("R6 urgent at L=2", {31'h0, urg_o[1]}, 32'h1);
    req = 2'b01; tick();
    chk("R8 urgent cleared on withdraw", {31'h0, urg_o[1]}, 32'h0);
    req = 2'b11; tick();
    chk("R8 count restarted", {31'h0, urg_o[1]}, 32'h0);
    tick();
    chk("R8 urgent again after L", {31'h0, urg_o[1]}, 32'h1);
    done = 2'b01; tick(); done = 2'b00; req = 2'b10; tick();
    done = 2'b10; tick(); done = 2'b00; req = 2'b00; tick();

    // R9: round-robin alternation at normal priority
    wr(32'h0000_FFFF);
    prev = 2'b00;
    req = 2'b11;
    for (int n = 0; n < 6; n++) begin
      tick();
      if (n > 0) chk("R9 alternation", {30'h0, gnt_o}, {30'h0, ~prev});
      prev = gnt_o;
      done = gnt_o; tick(); done = 2'b00;
    end
    req = 2'b00; tick();

    // random traffic against the model
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < 2; i++) begin
        if (m_gnt[i]) begin
          req[i] = 1'b1; done[i] = ($urandom % 4 == 0);
        end else begin
          done[i] = 1'b0;
          req[i] = req[i] ? ($urandom % 8 != 0) : ($urandom % 3 == 0);
        end
      end
      we = ($urandom % 20 == 0);
      wdata = {16'($urandom), 8'($urandom % 7), 8'($urandom % 7)};
      tick();
    end
    we = 1'b0; req = '0; done = '0; tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule